// File: doc/BRIEF.md
# Float-to-Unsigned-16 Conversion Unit

This block is a small pipelined execution unit. It takes a single-precision IEEE-754 value from a local file of eight 32-bit registers and turns it into an unsigned 16-bit integer. Any fraction is dropped, so the result truncates toward zero. Out-of-range inputs are clamped. The 16-bit result is zero-extended and written back into a destination register of the same file.

Work arrives as a 32-bit instruction word in two halfwords. The low halfword must carry the fixed operation code. The high halfword carries the source and destination register indices.

The result lands two cycles after issue. Software must keep the single slot in between free of any use of that destination. A new instruction can be issued every cycle.

A preload port fills registers directly. A combinational read port exposes any register so its contents can be observed. The unit has no status flags and changes none.

Top module: `f2u16_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register in the file reads 0x00000000 until it is written.
- R2: An issue is accepted only when `instr_lo_i` equals 0xE68E and bits 15:6 of `instr_hi_i` are all zero. Any other issue writes no register.
- R3: Bits 5:3 of `instr_hi_i` select the source register and bits 2:0 select the destination register.
- R4: A positive input with 1.0 <= x < 65536.0 yields its integer part, with the fraction discarded (for example 9.0 gives 9, 300.5 gives 300, 32769.5 gives 32769).
- R5: Bits 31:16 of the destination are always written as zero, whatever they held before.
- R6: An instruction issued in cycle n changes its destination so that the change is readable in cycle n+2 and not in cycle n+1. Issues in consecutive cycles are all accepted.
- R7: Every input with the sign bit set yields 0. This covers -9.0, -0.0, negative fractions, negative infinity and NaNs with the sign bit set.
- R8: Positive inputs below 1.0 yield 0. This covers +0.0, 0.5, the largest value below 1.0 and denormals.
- R9: Positive inputs at or above 65536.0, positive infinity and NaNs with the sign bit clear yield 0xFFFF.
- R10: A preload writes `load_data_i` into register `load_idx_i` at the clock edge. When a writeback and a preload hit the same register at the same edge, the writeback value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word present this cycle |
| instr_lo_i | input | 16 | Low halfword of the instruction (operation code) |
| instr_hi_i | input | 16 | High halfword of the instruction (register fields) |
| load_en_i | input | 1 | Preload strobe |
| load_idx_i | input | 3 | Preload register index |
| load_data_i | input | 32 | Preload data |
| rd_idx_i | input | 3 | Read port register index |
| rd_data_o | output | 32 | Read port data (combinational) |

## Verification
The bench builds the unit with its default parameters: eight registers, a 16-bit result and the 0xE68E operation code. With these values every exponent boundary of the conversion can be reached with a handful of constants. That includes the last in-range value near 65535, the saturation edge at 65536.0, the 1.0 threshold and the special encodings. All eight register indices can also be addressed through the 3-bit fields. The two-cycle visibility rule, the back-to-back issue, and the collision between a preload and a writeback are each driven at exact cycle offsets from issue.

// File: rtl/f2u16_pkg.sv
package f2u16_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int MANT_W = 23;
  localparam int BIAS   = 127;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } fp_word_t;
endpackage

// File: rtl/f2u16_decode.sv
module f2u16_decode #(
  parameter int          IDX_W  = 3,
  parameter logic [15:0] OPC_LO = 16'hE68E
) (
  input  logic [15:0]      lo_i,
  input  logic [15:0]      hi_i,
  output logic             match_o,
  output logic [IDX_W-1:0] src_o,
  output logic [IDX_W-1:0] dst_o
);
  localparam int FIELD_TOP = 2 * IDX_W;

  always_comb begin
    match_o = (lo_i == OPC_LO) && (hi_i[15:FIELD_TOP] == '0);
    src_o   = hi_i[FIELD_TOP-1:IDX_W];
    dst_o   = hi_i[IDX_W-1:0];
  end
endmodule

// File: rtl/f2u16_convert.sv
module f2u16_convert
  import f2u16_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  fp_word_t         op_i,
  output logic [INT_W-1:0] int_o
);
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_SAT = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [EXP_W-1:0] SH_BASE = EXP_W'(BIAS + MANT_W);

  logic [MANT_W:0]  full_sig;
  logic [EXP_W-1:0] sh_amt;

  always_comb begin
    full_sig = {1'b1, op_i.mant};
    sh_amt   = SH_BASE - op_i.expo;
    if (op_i.sign) begin
      int_o = '0;
    end else if (op_i.expo == EXP_TOP || op_i.expo >= EXP_SAT) begin
      int_o = '1;
    end else if (op_i.expo < EXP_ONE) begin
      int_o = '0;
    end else begin
      int_o = INT_W'(full_sig >> sh_amt);
    end
  end
endmodule

// File: rtl/f2u16_regfile.sv
module f2u16_regfile #(
  parameter int REGS  = 8,
  parameter int DW    = 32,
  parameter int IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [DW-1:0]    ld_data_i,
  input  logic             wb_en_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic [DW-1:0]    wb_data_i,
  input  logic [IDX_W-1:0] src_idx_i,
  output logic [DW-1:0]    src_data_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem_q [REGS];
  logic [DW-1:0] mem_d [REGS];

  always_comb begin
    for (int i = 0; i < REGS; i++) mem_d[i] = mem_q[i];
    if (ld_en_i) mem_d[ld_idx_i] = ld_data_i;
    if (wb_en_i) mem_d[wb_idx_i] = wb_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < REGS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign src_data_o = mem_q[src_idx_i];
  assign rd_data_o  = mem_q[rd_idx_i];

  // R10: writeback lands and wins over a same-index preload
  a_r10_wb_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_i |=> (mem_q[$past(wb_idx_i)] == $past(wb_data_i)));

  // R10: preload lands when no writeback targets the same index
  a_r10_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && !(wb_en_i && wb_idx_i == ld_idx_i))
      |=> (mem_q[$past(ld_idx_i)] == $past(ld_data_i)));
endmodule

// File: rtl/f2u16_unit.sv
module f2u16_unit
  import f2u16_pkg::*;
#(
  parameter int          REGS   = 8,
  parameter int          INT_W  = 16,
  parameter logic [15:0] OPC_LO = 16'hE68E
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_i,
  input  logic [15:0]              instr_lo_i,
  input  logic [15:0]              instr_hi_i,
  input  logic                     load_en_i,
  input  logic [$clog2(REGS)-1:0]  load_idx_i,
  input  logic [FP_W-1:0]          load_data_i,
  input  logic [$clog2(REGS)-1:0]  rd_idx_i,
  output logic [FP_W-1:0]          rd_data_o
);
  localparam int IDX_W = $clog2(REGS);
  localparam int PAD_W = FP_W - INT_W;

  logic             dec_match;
  logic [IDX_W-1:0] dec_src;
  logic [IDX_W-1:0] dec_dst;
  logic [FP_W-1:0]  src_data;
  logic             accept;

  // stage 1 state
  logic             s1_valid_q, s1_valid_d;
  logic [IDX_W-1:0] s1_dst_q,   s1_dst_d;
  fp_word_t         s1_op_q,    s1_op_d;
  logic             s1_en;

  // stage 2 (writeback) signals
  logic [INT_W-1:0] conv_int;
  logic [FP_W-1:0]  wb_data;

  f2u16_decode #(.IDX_W(IDX_W), .OPC_LO(OPC_LO)) u_decode (
    .lo_i    (instr_lo_i),
    .hi_i    (instr_hi_i),
    .match_o (dec_match),
    .src_o   (dec_src),
    .dst_o   (dec_dst)
  );

  assign accept = issue_i && dec_match;
  assign s1_en  = accept;

  always_comb begin
    s1_valid_d = accept;
    s1_dst_d   = dec_dst;
    s1_op_d    = fp_word_t'(src_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_dst_q <= '0;
      s1_op_q  <= '0;
    end else if (s1_en) begin
      s1_dst_q <= s1_dst_d;
      s1_op_q  <= s1_op_d;
    end
  end

  f2u16_convert #(.INT_W(INT_W)) u_convert (
    .op_i  (s1_op_q),
    .int_o (conv_int)
  );

  assign wb_data = {{PAD_W{1'b0}}, conv_int};

  f2u16_regfile #(.REGS(REGS), .DW(FP_W), .IDX_W(IDX_W)) u_regfile (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en_i    (load_en_i),
    .ld_idx_i   (load_idx_i),
    .ld_data_i  (load_data_i),
    .wb_en_i    (s1_valid_q),
    .wb_idx_i   (s1_dst_q),
    .wb_data_i  (wb_data),
    .src_idx_i  (dec_src),
    .src_data_o (src_data),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o)
  );

  // R6: an accepted issue always yields a writeback on the next edge
  a_r6_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_valid_q);

  // R2: nothing is written back without an accepted issue
  a_r2_no_spurious_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !s1_valid_q);

  // R5: writeback upper half is zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |-> (wb_data[FP_W-1:INT_W] == '0));

  // R7: sign set gives zero
  a_r7_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && s1_op_q.sign) |-> (conv_int == '0));

  // R9: large positive or special gives all ones
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && !s1_op_q.sign && s1_op_q.expo >= EXP_W'(BIAS + INT_W))
      |-> (conv_int == '1));

  // R8: positive below one gives zero
  a_r8_small_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && !s1_op_q.sign && s1_op_q.expo < EXP_W'(BIAS))
      |-> (conv_int == '0));
endmodule

// File: tb/f2u16_unit_tb.sv
module f2u16_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        issue_i;
  logic [15:0] instr_lo_i;
  logic [15:0] instr_hi_i;
  logic        load_en_i;
  logic [2:0]  load_idx_i;
  logic [31:0] load_data_i;
  logic [2:0]  rd_idx_i;
  logic [31:0] rd_data_o;

  int n_chk;
  int n_bad;
  bit done;

  localparam logic [15:0] OPC = 16'hE68E;

  f2u16_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .instr_lo_i  (instr_lo_i),
    .instr_hi_i  (instr_hi_i),
    .load_en_i   (load_en_i),
    .load_idx_i  (load_idx_i),
    .load_data_i (load_data_i),
    .rd_idx_i    (rd_idx_i),
    .rd_data_o   (rd_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] hi_word(input logic [2:0] src, input logic [2:0] dst);
    return {10'b0, src, dst};
  endfunction

  task automatic read_reg(input logic [2:0] idx, output logic [31:0] val);
    rd_idx_i = idx;
    #0.5;
    val = rd_data_o;
  endtask

  // at negedge: preload one register, return at following negedge
  task automatic preload(input logic [2:0] idx, input logic [31:0] d);
    load_en_i = 1'b1; load_idx_i = idx; load_data_i = d;
    @(negedge clk);
    load_en_i = 1'b0;
  endtask

  // drive one issue cycle; return at negedge after capture edge
  task automatic issue(input logic [15:0] lo, input logic [15:0] hi);
    issue_i = 1'b1; instr_lo_i = lo; instr_hi_i = hi;
    @(negedge clk);
    issue_i = 1'b0; instr_lo_i = '0; instr_hi_i = '0;
  endtask

  // preload src, convert into dst, check result after two cycles
  task automatic convert_one(input string tag, input logic [31:0] fp, input logic [31:0] exp);
    logic [31:0] v;
    preload(3'd1, fp);
    preload(3'd6, 32'hA5A5A5A5);
    issue(OPC, hi_word(3'd1, 3'd6));
    @(negedge clk);
    read_reg(3'd6, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      read_reg(3'(i), v);
      check("R1 reset value", v, 32'h0);
    end
  endtask

  task automatic t_truncate;
    convert_one("R4 9.0", 32'h41100000, 32'h00000009);
    convert_one("R4 1.0", 32'h3F800000, 32'h00000001);
    convert_one("R4 2.75", 32'h40300000, 32'h00000002);
    convert_one("R4 300.5", 32'h43964000, 32'h0000012C);
    convert_one("R4 32769.5", 32'h47000180, 32'h00008001);
    convert_one("R4 65535.0", 32'h477FFF00, 32'h0000FFFF);
  endtask

  task automatic t_negative;
    convert_one("R7 -9.0", 32'hC1100000, 32'h0);
    convert_one("R7 -0.0", 32'h80000000, 32'h0);
    convert_one("R7 -0.5", 32'hBF000000, 32'h0);
    convert_one("R7 -inf", 32'hFF800000, 32'h0);
    convert_one("R7 -NaN", 32'hFFC00000, 32'h0);
  endtask

  task automatic t_small;
    convert_one("R8 +0.0", 32'h00000000, 32'h0);
    convert_one("R8 0.5", 32'h3F000000, 32'h0);
    convert_one("R8 below one", 32'h3F7FFFFF, 32'h0);
    convert_one("R8 denormal", 32'h00000001, 32'h0);
  endtask

  task automatic t_saturate;
    convert_one("R9 65536.0", 32'h47800000, 32'h0000FFFF);
    convert_one("R9 1e9", 32'h4E6E6B28, 32'h0000FFFF);
    convert_one("R9 +inf", 32'h7F800000, 32'h0000FFFF);
    convert_one("R9 +NaN", 32'h7FC00000, 32'h0000FFFF);
  endtask

  task automatic t_upper_zero;
    logic [31:0] v;
    preload(3'd4, 32'h41100000);
    preload(3'd7, 32'hDEADBEEF);
    issue(OPC, hi_word(3'd4, 3'd7));
    @(negedge clk);
    read_reg(3'd7, v);
    check("R5 upper half cleared", v, 32'h00000009);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    preload(3'd4, 32'h43964000);
    preload(3'd5, 32'h11111111);
    preload(3'd3, 32'h22222222);
    issue(OPC, hi_word(3'd4, 3'd5));
    @(negedge clk);
    read_reg(3'd5, v);
    check("R3 dst 5 from src 4", v, 32'h0000012C);
    read_reg(3'd4, v);
    check("R3 src untouched", v, 32'h43964000);
    read_reg(3'd3, v);
    check("R3 other reg untouched", v, 32'h22222222);
  endtask

  task automatic t_bad_opcode;
    logic [31:0] v;
    preload(3'd0, 32'h41100000);
    preload(3'd2, 32'h33333333);
    issue(16'hE68F, hi_word(3'd0, 3'd2));
    @(negedge clk); @(negedge clk);
    read_reg(3'd2, v);
    check("R2 wrong low halfword ignored", v, 32'h33333333);
    issue(OPC, 16'h0040 | hi_word(3'd0, 3'd2));
    @(negedge clk); @(negedge clk);
    read_reg(3'd2, v);
    check("R2 nonzero high bits ignored", v, 32'h33333333);
    issue_i = 1'b0; instr_lo_i = OPC; instr_hi_i = hi_word(3'd0, 3'd2);
    @(negedge clk); @(negedge clk);
    instr_lo_i = '0; instr_hi_i = '0;
    read_reg(3'd2, v);
    check("R2 no issue strobe ignored", v, 32'h33333333);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    preload(3'd0, 32'h41100000);
    preload(3'd3, 32'h44444444);
    issue(OPC, hi_word(3'd0, 3'd3));
    read_reg(3'd3, v);
    check("R6 not visible at n+1", v, 32'h44444444);
    @(negedge clk);
    read_reg(3'd3, v);
    check("R6 visible at n+2", v, 32'h00000009);
  endtask

  task automatic t_back_to_back;
    logic [31:0] v;
    preload(3'd0, 32'h3F800000);
    preload(3'd1, 32'h47000180);
    issue(OPC, hi_word(3'd0, 3'd2));
    issue(OPC, hi_word(3'd1, 3'd3));
    @(negedge clk);
    read_reg(3'd2, v);
    check("R6 back-to-back first", v, 32'h00000001);
    read_reg(3'd3, v);
    check("R6 back-to-back second", v, 32'h00008001);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    preload(3'd0, 32'h41100000);
    preload(3'd2, 32'h55555555);
    issue(OPC, hi_word(3'd0, 3'd2));
    preload(3'd2, 32'h66666666);
    read_reg(3'd2, v);
    check("R10 writeback beats preload", v, 32'h00000009);
    preload(3'd2, 32'h77777777);
    read_reg(3'd2, v);
    check("R10 preload lands", v, 32'h77777777);
  endtask

  initial begin
    done = 1'b0;
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; issue_i = 1'b0; instr_lo_i = '0; instr_hi_i = '0;
    load_en_i = 1'b0; load_idx_i = '0; load_data_i = '0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_truncate();
    t_negative();
    t_small();
    t_saturate();
    t_upper_zero();
    t_fields();
    t_bad_opcode();
    t_latency();
    t_back_to_back();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule